// File: doc/BRIEF.md
# Multiplexed-Bus Dual-Bank Register Front End

This block is the host-side front end of a small peripheral attached to a multiplexed 8-bit address/data bus. On the falling edge of the address strobe it captures the bus value as an index. A sideband bank pin decides which of two independent index latches receives it, a standard bank and an extended bank. During the data phase the level of the same pin picks the latch, and therefore the bank location, that the access reaches. The access goes out on a simple register-file port: bank, 7-bit address, write strobe and write data, with read data returned combinationally.

A strap input selects one of two strobe conventions. With the strap high, a data strobe qualifies the access and a read/write level gives its direction. With the strap low, the data-strobe pin is an active-low read enable and the read/write pin is an active-low write strobe that commits on its rising edge. Every bus pin is synchronised to the system clock, so the block uses one clock domain.

Each bank has a shadow copy of its last captured index. The shadows are readable at the top two extended-bank locations, each next to a status bit supplied from outside. A RAM-clear input that stays low for a qualified number of slow ticks fills every general storage byte with FFh, one byte per clock, and zeroes both shadows.

Top module: `mxbus_bank_if`

## Requirements
- R1: On a falling edge of the address strobe the bus bits 6:0 are captured into the standard-bank index when the bank pin is low, or into the extended-bank index when it is high, whether or not chip select is asserted. The other bank's index and shadow keep their values. The captured value appears on that bank's shadow output.
- R2: Outside a clear, rf_bank_o follows the synchronised bank pin and rf_addr_o shows the index latched for that bank.
- R3: With the strap high, chip select low, read/write high and data strobe high, ad_oe_o is 1 and ad_o carries the read data for the addressed location.
- R4: With the strap high, a falling data strobe while read/write is low and chip select is low gives exactly one cycle of rf_wdata_o, equal to the bus value, with rf_we_o high.
- R5: With the strap low, chip select low and the data-strobe pin low, ad_oe_o is 1 and ad_o carries the read data.
- R6: With the strap low, a rising edge on the read/write pin while chip select is low gives exactly one write cycle of the bus value.
- R7: While chip select is high, ad_oe_o stays 0 and no bus write reaches rf_we_o.
- R8: In the extended bank, location 7Eh reads as {flag_i, standard shadow} and location 7Fh reads as {cent_i, extended shadow}. Bus writes to either location never assert rf_we_o.
- R9: When clr_n_i stays low for QUAL_TICKS tick_i pulses, the block writes FFh to standard locations 0Eh to 7Fh and then to extended locations 00h to 7Dh, one per clock (240 writes), and both shadows become 00h. Standard locations 00h to 0Dh are not written. A clear fires only once for each low period.
- R10: If clr_n_i returns high before QUAL_TICKS ticks, no clear takes place, and the qualification count starts again from zero.
- R11: After reset both shadows are 00h, and ad_oe_o and rf_we_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | Strap: 1 = data strobe plus direction level, 0 = separate read/write strobes |
| as_i | input | 1 | Address strobe, captures on falling edge |
| ds_i | input | 1 | Data strobe (mode 1) or active-low read enable (mode 0) |
| rw_i | input | 1 | Direction level (mode 1) or active-low write strobe (mode 0) |
| cs_n_i | input | 1 | Active-low chip select |
| bank_i | input | 1 | Bank select: 0 standard, 1 extended |
| ad_i | input | 8 | Bus value driven by the host |
| ad_o | output | 8 | Read data for the bus |
| ad_oe_o | output | 1 | Bus output enable |
| clr_n_i | input | 1 | Active-low RAM-clear request |
| tick_i | input | 1 | Slow enable tick for clear qualification |
| flag_i | input | 1 | Status bit shown at extended 7Eh bit 7 |
| cent_i | input | 1 | Century bit shown at extended 7Fh bit 7 |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_bank_o | output | 1 | Register-file bank |
| rf_addr_o | output | 7 | Register-file location |
| rf_wdata_o | output | 8 | Register-file write data |
| rf_rdata_i | input | 8 | Register-file read data for rf_bank_o/rf_addr_o |
| shd_std_o | output | 7 | Standard-bank shadow index |
| shd_ext_o | output | 7 | Extended-bank shadow index |

## Verification
Every pin passes through two synchroniser stages. A level-driven result (the output enable, the bank and address steering) is therefore valid two clocks after the pin changes. A write pulse is visible in the cycle that follows the second edge, and a captured index reaches its shadow one clock after that. The bench changes pins on falling clock edges, waits four clocks before it samples, and counts write strobes at every rising edge, so each check falls after its result is settled. Clear qualification is timed in ticks, and the bench waits well short of or well beyond the threshold.

// File: rtl/mxb_pkg.sv
package mxb_pkg;

    localparam int unsigned BUS_W = 8;
    localparam int unsigned IDX_W = 7;

    typedef enum logic {
        BANK_STD = 1'b0,
        BANK_EXT = 1'b1
    } bank_e;

    // Bus pins as one bundle so they share one synchroniser chain.
    typedef struct packed {
        logic             as;
        logic             ds;
        logic             rw;
        logic             cs_n;
        bank_e            bank;
        logic             clr_n;
        logic [BUS_W-1:0] ad;
    } pins_t;

    localparam pins_t PINS_IDLE = '{as: 1'b0, ds: 1'b0, rw: 1'b1, cs_n: 1'b1,
                                    bank: BANK_STD, clr_n: 1'b1, ad: '0};

    typedef struct packed {
        logic rd_en;
        logic wr_stb;
        logic as_fall;
    } strobe_t;

    localparam logic [IDX_W-1:0] LOC_SHD_STD     = 7'h7E;
    localparam logic [IDX_W-1:0] LOC_SHD_EXT     = 7'h7F;
    localparam logic [IDX_W-1:0] STD_STORE_FIRST = 7'h0E;
    localparam logic [IDX_W-1:0] STD_STORE_LAST  = 7'h7F;
    localparam logic [IDX_W-1:0] EXT_STORE_LAST  = 7'h7D;
    localparam logic [BUS_W-1:0] FILL_BYTE       = 8'hFF;

    function automatic logic is_shadow_loc(bank_e b, logic [IDX_W-1:0] idx);
        return (b == BANK_EXT) && ((idx == LOC_SHD_STD) || (idx == LOC_SHD_EXT));
    endfunction

endpackage

// File: rtl/mxb_sync.sv
module mxb_sync #(
    parameter int          W       = 8,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[LAST];
endmodule

// File: rtl/mxb_strobe_dec.sv
module mxb_strobe_dec
    import mxb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    mode,
    input  pins_t   cur,
    output strobe_t st
);
    logic prev_as, prev_ds, prev_rw;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_as <= PINS_IDLE.as;
            prev_ds <= PINS_IDLE.ds;
            prev_rw <= PINS_IDLE.rw;
        end else begin
            prev_as <= cur.as;
            prev_ds <= cur.ds;
            prev_rw <= cur.rw;
        end
    end

    logic sel;
    assign sel = !cur.cs_n;

    always_comb begin
        st.as_fall = prev_as && !cur.as;
        if (mode) begin
            st.rd_en  = sel && cur.ds && cur.rw;
            st.wr_stb = sel && prev_ds && !cur.ds && !cur.rw;
        end else begin
            st.rd_en  = sel && !cur.ds;
            st.wr_stb = sel && !prev_rw && cur.rw;
        end
    end
endmodule

// File: rtl/mxb_addr_latch.sv
module mxb_addr_latch
    import mxb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cap,
    input  bank_e            cap_bank,
    input  logic [IDX_W-1:0] cap_idx,
    input  logic             wipe,
    input  bank_e            sel_bank,
    output logic [IDX_W-1:0] sel_idx,
    output logic [IDX_W-1:0] shd_std,
    output logic [IDX_W-1:0] shd_ext
);
    logic [1:0][IDX_W-1:0] lat;
    logic [1:0][IDX_W-1:0] shd;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat <= '0;
            shd <= '0;
        end else begin
            if (cap) lat[cap_bank] <= cap_idx;
            if (wipe)     shd <= '0;
            else if (cap) shd[cap_bank] <= cap_idx;
        end
    end

    assign sel_idx = lat[sel_bank];
    assign shd_std = shd[BANK_STD];
    assign shd_ext = shd[BANK_EXT];
endmodule

// File: rtl/mxb_clear_seq.sv
module mxb_clear_seq
    import mxb_pkg::*;
#(
    parameter int QUAL_TICKS = 125
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             clr_n,
    output logic             go,
    output logic             busy,
    output bank_e            wbank,
    output logic [IDX_W-1:0] waddr
);
    localparam int CNT_W = $clog2(QUAL_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(QUAL_TICKS - 1);

    logic [CNT_W-1:0] cnt;
    logic             fired;

    assign go = !clr_n && tick && !fired && (cnt == CNT_TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            fired <= 1'b0;
        end else if (clr_n) begin
            cnt   <= '0;
            fired <= 1'b0;
        end else if (go) begin
            fired <= 1'b1;
        end else if (tick && !fired) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            wbank <= BANK_STD;
            waddr <= '0;
        end else if (go) begin
            busy  <= 1'b1;
            wbank <= BANK_STD;
            waddr <= STD_STORE_FIRST;
        end else if (busy) begin
            if (wbank == BANK_STD && waddr == STD_STORE_LAST) begin
                wbank <= BANK_EXT;
                waddr <= '0;
            end else if (wbank == BANK_EXT && waddr == EXT_STORE_LAST) begin
                busy <= 1'b0;
            end else begin
                waddr <= waddr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mxbus_bank_if.sv
module mxbus_bank_if
    import mxb_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_TICKS  = 125
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_i,
    input  logic             as_i,
    input  logic             ds_i,
    input  logic             rw_i,
    input  logic             cs_n_i,
    input  logic             bank_i,
    input  logic [BUS_W-1:0] ad_i,
    output logic [BUS_W-1:0] ad_o,
    output logic             ad_oe_o,
    input  logic             clr_n_i,
    input  logic             tick_i,
    input  logic             flag_i,
    input  logic             cent_i,
    output logic             rf_we_o,
    output logic             rf_bank_o,
    output logic [IDX_W-1:0] rf_addr_o,
    output logic [BUS_W-1:0] rf_wdata_o,
    input  logic [BUS_W-1:0] rf_rdata_i,
    output logic [IDX_W-1:0] shd_std_o,
    output logic [IDX_W-1:0] shd_ext_o
);
    localparam int PW = $bits(pins_t);

    pins_t   raw, cur;
    strobe_t st;

    assign raw = '{as: as_i, ds: ds_i, rw: rw_i, cs_n: cs_n_i,
                   bank: bank_e'(bank_i), clr_n: clr_n_i, ad: ad_i};

    mxb_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (cur)
    );

    mxb_strobe_dec u_dec (
        .clk  (clk),
        .rst  (rst),
        .mode (mode_i),
        .cur  (cur),
        .st   (st)
    );

    logic             clr_go, clr_busy;
    bank_e            clr_bank;
    logic [IDX_W-1:0] clr_addr;

    mxb_clear_seq #(.QUAL_TICKS(QUAL_TICKS)) u_clr (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick_i),
        .clr_n (cur.clr_n),
        .go    (clr_go),
        .busy  (clr_busy),
        .wbank (clr_bank),
        .waddr (clr_addr)
    );

    logic [IDX_W-1:0] idx;

    mxb_addr_latch u_lat (
        .clk      (clk),
        .rst      (rst),
        .cap      (st.as_fall),
        .cap_bank (cur.bank),
        .cap_idx  (cur.ad[IDX_W-1:0]),
        .wipe     (clr_go),
        .sel_bank (cur.bank),
        .sel_idx  (idx),
        .shd_std  (shd_std_o),
        .shd_ext  (shd_ext_o)
    );

    logic bus_wr_ok;
    assign bus_wr_ok = st.wr_stb && !is_shadow_loc(cur.bank, idx);

    always_comb begin
        if (clr_busy) begin
            rf_we_o    = 1'b1;
            rf_bank_o  = clr_bank;
            rf_addr_o  = clr_addr;
            rf_wdata_o = FILL_BYTE;
        end else begin
            rf_we_o    = bus_wr_ok;
            rf_bank_o  = cur.bank;
            rf_addr_o  = idx;
            rf_wdata_o = cur.ad;
        end
    end

    assign ad_oe_o = st.rd_en && !clr_busy;

    always_comb begin
        if (cur.bank == BANK_EXT && idx == LOC_SHD_STD)
            ad_o = {flag_i, shd_std_o};
        else if (cur.bank == BANK_EXT && idx == LOC_SHD_EXT)
            ad_o = {cent_i, shd_ext_o};
        else
            ad_o = rf_rdata_i;
    end
endmodule

// File: rtl/mxb_chk.sv
module mxb_chk (
    input logic       clk,
    input logic       rst,
    input logic       ad_oe_o,
    input logic       cs_s,
    input logic       rf_we_o,
    input logic       rf_bank_o,
    input logic [6:0] rf_addr_o,
    input logic [7:0] rf_wdata_o,
    input logic       clr_busy,
    input logic       clr_go,
    input logic       as_fall,
    input logic       bank_s,
    input logic [6:0] ad_s,
    input logic [6:0] shd_std_o,
    input logic [6:0] shd_ext_o
);
    assert_cs_blocks_drive_R7: assert property (@(posedge clk) disable iff (rst)
        ad_oe_o |-> !cs_s);

    assert_clear_fill_R9: assert property (@(posedge clk) disable iff (rst)
        clr_busy |-> (rf_we_o && rf_wdata_o == 8'hFF));

    assert_clear_spares_clock_regs_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_busy && !rf_bank_o) |-> (rf_addr_o >= 7'h0E));

    assert_shadow_read_only_R8: assert property (@(posedge clk) disable iff (rst)
        (rf_we_o && !clr_busy && rf_bank_o) |-> (rf_addr_o < 7'h7E));

    assert_std_capture_R1: assert property (@(posedge clk) disable iff (rst)
        (as_fall && !bank_s && !clr_go) |=> (shd_std_o == $past(ad_s)));

    assert_ext_capture_R1: assert property (@(posedge clk) disable iff (rst)
        (as_fall && bank_s && !clr_go) |=> (shd_ext_o == $past(ad_s)));

    assert_single_write_R4: assert property (@(posedge clk) disable iff (rst)
        (rf_we_o && !clr_busy) |=> !(rf_we_o && !clr_busy));
endmodule

bind mxbus_bank_if mxb_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ad_oe_o    (ad_oe_o),
    .cs_s       (cur.cs_n),
    .rf_we_o    (rf_we_o),
    .rf_bank_o  (rf_bank_o),
    .rf_addr_o  (rf_addr_o),
    .rf_wdata_o (rf_wdata_o),
    .clr_busy   (clr_busy),
    .clr_go     (clr_go),
    .as_fall    (st.as_fall),
    .bank_s     (cur.bank),
    .ad_s       (cur.ad[6:0]),
    .shd_std_o  (shd_std_o),
    .shd_ext_o  (shd_ext_o)
);

// File: tb/sim_mxbus_bank_if.sv
`timescale 1ns/1ps
module sim_mxbus_bank_if;
    localparam int QT = 125;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode = 1'b1, as_p = 1'b0, ds = 1'b0, rw = 1'b1, cs_n = 1'b1, bank = 1'b0;
    logic [7:0] ad_i = 8'h00;
    logic [7:0] ad_o;
    logic       ad_oe;
    logic       clr_n = 1'b1, tick = 1'b0, flag = 1'b1, cent = 1'b0;
    logic       rf_we, rf_bank;
    logic [6:0] rf_addr, shd_std, shd_ext;
    logic [7:0] rf_wdata, rf_rdata;

    always #4 clk = ~clk;

    mxbus_bank_if #(.QUAL_TICKS(QT)) u0 (
        .clk(clk), .rst(rst), .mode_i(mode), .as_i(as_p), .ds_i(ds), .rw_i(rw),
        .cs_n_i(cs_n), .bank_i(bank), .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe),
        .clr_n_i(clr_n), .tick_i(tick), .flag_i(flag), .cent_i(cent),
        .rf_we_o(rf_we), .rf_bank_o(rf_bank), .rf_addr_o(rf_addr),
        .rf_wdata_o(rf_wdata), .rf_rdata_i(rf_rdata),
        .shd_std_o(shd_std), .shd_ext_o(shd_ext)
    );

    // Register-file model and write counter
    logic [7:0] mem [2][128];
    logic [7:0] expm [2][128];
    int we_count = 0;
    logic [1:0] tdiv = 2'd0;

    assign rf_rdata = mem[rf_bank][rf_addr];

    always @(posedge clk) begin
        tdiv <= tdiv + 2'd1;
        tick <= (tdiv == 2'd3);
        if (rf_we) begin
            mem[rf_bank][rf_addr] <= rf_wdata;
            we_count <= we_count + 1;
        end
    end

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_addr(bit b, logic [6:0] a);
        bank = b; ad_i = {1'b0, a}; as_p = 1'b1; cyc(4);
        as_p = 1'b0; cyc(4);
    endtask

    function automatic bit writable(bit b, logic [6:0] a);
        return !(b && a >= 7'h7E);
    endfunction

    task automatic bus_wr(bit b, logic [6:0] a, logic [7:0] d);
        bus_addr(b, a);
        ad_i = d; cs_n = 1'b0;
        if (mode) begin
            rw = 1'b0; cyc(4); ds = 1'b1; cyc(4); ds = 1'b0; cyc(4); rw = 1'b1;
        end else begin
            rw = 1'b0; cyc(4); rw = 1'b1; cyc(4);
        end
        cs_n = 1'b1; cyc(4);
        if (writable(b, a)) expm[b][a] = d;
    endtask

    task automatic bus_rd(bit b, logic [6:0] a, output logic oe, output logic [7:0] d);
        bus_addr(b, a);
        ad_i = 8'h00; cs_n = 1'b0;
        if (mode) begin rw = 1'b1; ds = 1'b1; end else ds = 1'b0;
        cyc(4);
        oe = ad_oe; d = ad_o;
        if (mode) ds = 1'b0; else ds = 1'b1;
        cyc(4); cs_n = 1'b1; cyc(2);
    endtask

    task automatic set_mode(logic m);
        cs_n = 1'b1; rw = 1'b1; ds = m ? 1'b0 : 1'b1; cyc(4);
        mode = m; cyc(4);
    endtask

    initial begin
        logic       oe;
        logic [7:0] d;
        int         w0, bad;
        void'($urandom(32'd2024));
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 128; i++) begin
                mem[b][i]  = 8'(i * 3 + b * 7);
                expm[b][i] = 8'(i * 3 + b * 7);
            end
        cyc(5); rst = 1'b0; cyc(4);

        // R11: reset state
        chk("R11 shd_std", shd_std, 0);
        chk("R11 shd_ext", shd_ext, 0);
        chk("R11 oe", ad_oe, 0);
        chk("R11 we", rf_we, 0);

        // R1: capture into the selected bank only, chip select ignored
        bus_addr(1'b0, 7'h15);
        chk("R1 std capture", shd_std, 7'h15);
        chk("R1 ext untouched", shd_ext, 7'h00);
        cs_n = 1'b0; bus_addr(1'b1, 7'h2A); cs_n = 1'b1; cyc(2);
        chk("R1 ext capture cs low", shd_ext, 7'h2A);
        chk("R1 std untouched", shd_std, 7'h15);

        // R2: data-phase bank steering
        bank = 1'b1; cyc(4);
        chk("R2 bank ext", {rf_bank, rf_addr}, {1'b1, 7'h2A});
        bank = 1'b0; cyc(4);
        chk("R2 bank std", {rf_bank, rf_addr}, {1'b0, 7'h15});

        // R7: chip select high blocks reads and writes (data-strobe mode)
        w0 = we_count;
        bus_addr(1'b0, 7'h20);
        ad_i = 8'h5A; rw = 1'b0; cyc(4); ds = 1'b1; cyc(4); ds = 1'b0; cyc(4); rw = 1'b1;
        ds = 1'b1; cyc(4);
        chk("R7 no drive", ad_oe, 0);
        ds = 1'b0; cyc(4);
        chk("R7 no write", we_count - w0, 0);

        // R4/R3 directed, then R6/R5 directed
        w0 = we_count;
        bus_wr(1'b0, 7'h00, 8'hC3);
        chk("R4 one pulse", we_count - w0, 1);
        bus_rd(1'b0, 7'h00, oe, d);
        chk("R3 oe", oe, 1);
        chk("R3 data", d, 8'hC3);
        set_mode(1'b0);
        w0 = we_count;
        bus_wr(1'b1, 7'h7D, 8'h81);
        chk("R6 one pulse", we_count - w0, 1);
        bus_rd(1'b1, 7'h7D, oe, d);
        chk("R5 oe", oe, 1);
        chk("R5 data", d, 8'h81);

        // R8: shadow locations
        w0 = we_count;
        bus_wr(1'b1, 7'h7E, 8'h11);
        bus_wr(1'b1, 7'h7F, 8'h22);
        chk("R8 writes dropped", we_count - w0, 0);
        bus_wr(1'b0, 7'h33, 8'h44);
        bus_rd(1'b1, 7'h7E, oe, d);
        chk("R8 7E read", d, {flag, 7'h33});
        cent = 1'b1;
        bus_rd(1'b1, 7'h7F, oe, d);
        chk("R8 7F read", d, {1'b1, 7'h7F});

        // Random mix across both modes
        for (int it = 0; it < 30; it++) begin
            bit         rb;
            logic [6:0] ra;
            logic [7:0] rd;
            rb = 1'($urandom);
            ra = 7'($urandom);
            rd = 8'($urandom);
            if (!writable(rb, ra)) ra = 7'h40;
            set_mode(1'($urandom));
            bus_wr(rb, ra, rd);
            bus_rd(rb, ra, oe, d);
            if (mode) chk("R4 R3 random", {oe, d}, {1'b1, expm[rb][ra]});
            else      chk("R6 R5 random", {oe, d}, {1'b1, expm[rb][ra]});
        end
        set_mode(1'b1);

        // R10: short clear request does nothing
        bus_addr(1'b1, 7'h12);
        bus_addr(1'b0, 7'h09);
        w0 = we_count;
        clr_n = 1'b0; cyc(100 * 4); clr_n = 1'b1; cyc(10);
        chk("R10 no writes", we_count - w0, 0);
        chk("R10 shadow kept", {shd_std, shd_ext}, {7'h09, 7'h12});
        clr_n = 1'b0; cyc(100 * 4); clr_n = 1'b1; cyc(10);
        chk("R10 count restarts", we_count - w0, 0);

        // R9: qualified clear
        clr_n = 1'b0; cyc(130 * 4 + 400); clr_n = 1'b1; cyc(10);
        chk("R9 write count", we_count - w0, 240);
        chk("R9 shadows zero", {shd_std, shd_ext}, 0);
        bad = 0;
        for (int i = 0; i < 128; i++) begin
            logic [7:0] es, ee;
            es = (i < 14) ? expm[0][i] : 8'hFF;
            ee = (i < 126) ? 8'hFF : expm[1][i];
            if (mem[0][i] !== es) bad++;
            if (mem[1][i] !== ee) bad++;
            expm[0][i] = es; expm[1][i] = ee;
        end
        chk("R9 storage filled, clock regs kept", bad, 0);
        bus_rd(1'b1, 7'h10, oe, d);
        chk("R9 readback", d, 8'hFF);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule